// File: doc/BRIEF.md
# Stochastic Bitstream Multiply and Scaled-Add Unit

This block does arithmetic on numbers carried as random bitstreams. Each operand is a fraction in [0,1], held as the chance that a bit of its stream is one. Three binary fractions go in: two data operands and a select weight. Each one becomes a serial stream, one bit per clock. The stream bit is one whenever a pseudo-random word from that operand's own linear feedback shift register is below the operand. No binary multiplier or adder appears in the datapath. A single AND gate of the two data streams forms their product. A two-input multiplexer steered by the select stream forms the weighted sum s*a + (1-s)*b.

A start pulse launches a run of a fixed number of cycles. During the run both result streams appear on serial outputs. Two counters tally the ones in the product stream and in the sum stream. When the run ends, the block raises done for one cycle and presents both tallies as binary estimates. A start pulse that arrives while a run is in progress is dropped.

Top module: `sc_arith_unit`

## Requirements
- R1: After synchronous active-high reset, busy, done, stream_valid, prod_bit and sum_bit are 0, and prod_est and sum_est are 0.
- R2: A start sampled high while idle latches op_a, op_b and op_s and raises busy at that edge. The run lasts exactly 2**WIDTH clock cycles (256 by default). The edge that ends it drops busy and raises done, and done stays high for exactly one cycle.
- R3: Each operand has its own 8-bit right-shifting Galois LFSR with feedback mask 0xB8. The next state is (x>>1) XOR (0xB8 if bit 0 of x is 1, else 0). The seeds are 0x01 for op_a, 0x5A for op_b and 0xC3 for op_s. Each LFSR is reloaded with its seed at the start edge and advances once per run cycle. In run cycle k, starting from k=0, the stream bit is 1 exactly when the LFSR value, after k advances, is less than the latched operand.
- R4: The product stream bit equals the AND of the op_a and op_b stream bits.
- R5: The sum stream bit equals the op_a stream bit when the op_s stream bit is 1, and the op_b stream bit otherwise.
- R6: At done, prod_est and sum_est equal the number of ones in the product and sum streams over the run, saturated at 255. They hold their value until the next done.
- R7: An operand of 0 gives an all-zero stream, so op_a = 0 forces prod_est = 0 and an all-zero prod_bit sequence.
- R8: An operand of 255 gives at most one zero bit per 256-cycle run, so op_a = op_b = 255 gives prod_est >= 254.
- R9: A start pulse while busy is ignored. The run length and the latched operands stay unchanged, and no second run follows.
- R10: stream_valid, prod_bit and sum_bit are registered. stream_valid is high for the 256 cycles that follow the 256 run edges, and each prod_bit/sum_bit equals the stream bit formed in the run cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run launch pulse, taken only when idle |
| op_a | input | WIDTH | First data operand, a fraction of 2**WIDTH |
| op_b | input | WIDTH | Second data operand |
| op_s | input | WIDTH | Select weight for the scaled sum |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the estimates are updated |
| prod_est | output | WIDTH | Ones count of the product stream, saturated |
| sum_est | output | WIDTH | Ones count of the scaled-sum stream, saturated |
| stream_valid | output | 1 | prod_bit and sum_bit carry run bits |
| prod_bit | output | 1 | Serial product stream |
| sum_bit | output | 1 | Serial scaled-sum stream |

## Verification
The assertions check four things on every cycle. Done is a single-cycle pulse that comes only as a run ends. The run counter steps by one and the latched operands stay fixed while busy, whatever start does. A product bit never appears without a sum bit. A zero first operand never lets a product bit through. The bench covers what needs a whole run. It computes exact ones counts for a 16 by 16 grid of operand pairs from the stated LFSR sequences, measures the run length and the serial output tally, and checks the ends of the operand range, where only full-run totals show whether the comparison and saturation are right.

// File: rtl/sc_arith_pkg.sv
package sc_arith_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_t;
  localparam int NUM_STREAMS = 3;
endpackage

// File: rtl/sc_lfsr.sv
module sc_lfsr #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] MASK = 8'hB8,
  parameter logic [WIDTH-1:0] SEED = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             adv,
  output logic [WIDTH-1:0] state
);
  logic [WIDTH-1:0] nxt;

  always_comb begin
    nxt = {1'b0, state[WIDTH-1:1]};
    if (state[0]) nxt = nxt ^ MASK;
  end

  always_ff @(posedge clk) begin
    if (rst || load) state <= SEED;
    else if (adv)    state <= nxt;
  end
endmodule

// File: rtl/sc_stream_gen.sv
module sc_stream_gen #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] MASK = 8'hB8,
  parameter logic [WIDTH-1:0] SEED = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             adv,
  input  logic [WIDTH-1:0] level,
  output logic             bit_o
);
  logic [WIDTH-1:0] rnd;

  sc_lfsr #(.WIDTH(WIDTH), .MASK(MASK), .SEED(SEED)) lfsr_i (
    .clk(clk), .rst(rst), .load(load), .adv(adv), .state(rnd)
  );

  assign bit_o = (rnd < level);
endmodule

// File: rtl/sc_ones_acc.sv
module sc_ones_acc #(
  parameter int WIDTH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           en,
  input  logic           bit_i,
  output logic [WIDTH:0] total_nxt
);
  logic [WIDTH:0] total;

  assign total_nxt = total + {{WIDTH{1'b0}}, bit_i};

  always_ff @(posedge clk) begin
    if (rst || clr) total <= '0;
    else if (en)    total <= total_nxt;
  end
endmodule

// File: rtl/sc_arith_unit.sv
module sc_arith_unit
  import sc_arith_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8,
  parameter logic [WIDTH-1:0] SEED_A = 8'h01,
  parameter logic [WIDTH-1:0] SEED_B = 8'h5A,
  parameter logic [WIDTH-1:0] SEED_S = 8'hC3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [WIDTH-1:0] op_s,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] prod_est,
  output logic [WIDTH-1:0] sum_est,
  output logic             stream_valid,
  output logic             prod_bit,
  output logic             sum_bit
);
  localparam int PACK_W = NUM_STREAMS * WIDTH;
  localparam logic [PACK_W-1:0] SEED_PACK = {SEED_S, SEED_B, SEED_A};
  localparam logic [WIDTH-1:0] LAST_CNT = {WIDTH{1'b1}};

  run_state_t        st;
  logic [WIDTH-1:0]  run_cnt;
  logic [PACK_W-1:0] op_q;
  logic [NUM_STREAMS-1:0] sbit;
  logic              load, run, last;
  logic              prod_raw, sum_raw;
  logic [WIDTH:0]    prod_nxt, sum_nxt;

  assign run  = (st == ST_RUN);
  assign load = (st == ST_IDLE) && start;
  assign last = run && (run_cnt == LAST_CNT);
  assign busy = run;

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_stream
    sc_stream_gen #(
      .WIDTH(WIDTH), .MASK(TAP_MASK), .SEED(SEED_PACK[g*WIDTH +: WIDTH])
    ) gen_i (
      .clk(clk), .rst(rst), .load(load), .adv(run),
      .level(op_q[g*WIDTH +: WIDTH]), .bit_o(sbit[g])
    );
  end

  assign prod_raw = sbit[0] & sbit[1];
  assign sum_raw  = sbit[2] ? sbit[0] : sbit[1];

  sc_ones_acc #(.WIDTH(WIDTH)) prod_acc_i (
    .clk(clk), .rst(rst), .clr(load), .en(run), .bit_i(prod_raw), .total_nxt(prod_nxt)
  );
  sc_ones_acc #(.WIDTH(WIDTH)) sum_acc_i (
    .clk(clk), .rst(rst), .clr(load), .en(run), .bit_i(sum_raw), .total_nxt(sum_nxt)
  );

  function automatic logic [WIDTH-1:0] sat_est(input logic [WIDTH:0] v);
    return v[WIDTH] ? {WIDTH{1'b1}} : v[WIDTH-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      run_cnt      <= '0;
      op_q         <= '0;
      done         <= 1'b0;
      prod_est     <= '0;
      sum_est      <= '0;
      stream_valid <= 1'b0;
      prod_bit     <= 1'b0;
      sum_bit      <= 1'b0;
    end else begin
      done         <= 1'b0;
      stream_valid <= run;
      prod_bit     <= run & prod_raw;
      sum_bit      <= run & sum_raw;
      if (load) begin
        st      <= ST_RUN;
        run_cnt <= '0;
        op_q    <= {op_s, op_b, op_a};
      end else if (run) begin
        run_cnt <= run_cnt + 1'b1;
        if (last) begin
          st       <= ST_IDLE;
          done     <= 1'b1;
          prod_est <= sat_est(prod_nxt);
          sum_est  <= sat_est(sum_nxt);
        end
      end
    end
  end
endmodule

// File: rtl/sc_arith_unit_checker.sv
module sc_arith_unit_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             stream_valid,
  input logic             prod_bit,
  input logic             sum_bit,
  input logic [WIDTH-1:0] run_cnt,
  input logic [3*WIDTH-1:0] op_q
);
  localparam logic [WIDTH-1:0] LAST_CNT = {WIDTH{1'b1}};

  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_at_run_end_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_run_steps_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && run_cnt != LAST_CNT) |=> (busy && run_cnt == $past(run_cnt) + 1'b1));

  assert_ops_held_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(op_q));

  assert_prod_implies_sum_R5: assert property (@(posedge clk) disable iff (rst)
    prod_bit |-> sum_bit);

  assert_zero_blocks_prod_R7: assert property (@(posedge clk) disable iff (rst)
    (stream_valid && op_q[WIDTH-1:0] == '0) |-> !prod_bit);

  assert_valid_follows_run_R10: assert property (@(posedge clk) disable iff (rst)
    stream_valid |-> $past(busy));
endmodule

bind sc_arith_unit sc_arith_unit_checker #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .stream_valid(stream_valid), .prod_bit(prod_bit), .sum_bit(sum_bit),
  .run_cnt(run_cnt), .op_q(op_q)
);

// File: tb/sc_arith_unit_tb.sv
module sc_arith_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int RUN_LEN = 256;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, op_s = '0;
  logic busy, done, stream_valid, prod_bit, sum_bit;
  logic [W-1:0] prod_est, sum_est;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  sc_arith_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b), .op_s(op_s),
    .busy(busy), .done(done), .prod_est(prod_est), .sum_est(sum_est),
    .stream_valid(stream_valid), .prod_bit(prod_bit), .sum_bit(sum_bit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= WATCHDOG) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  function automatic logic [7:0] step(input logic [7:0] x);
    return {1'b0, x[7:1]} ^ (x[0] ? 8'hB8 : 8'h00);
  endfunction

  // Exact ones counts from the R3 stream definition, R4 AND and R5 mux
  task automatic model(input logic [7:0] a, b, s, output int pc, output int sc);
    logic [7:0] la, lb, ls;
    la = 8'h01; lb = 8'h5A; ls = 8'hC3;
    pc = 0; sc = 0;
    for (int k = 0; k < RUN_LEN; k++) begin
      logic ba, bb, bs;
      ba = (la < a); bb = (lb < b); bs = (ls < s);
      pc += int'(ba & bb);
      sc += int'(bs ? ba : bb);
      la = step(la); lb = step(lb); ls = step(ls);
    end
  endtask

  function automatic int sat(input int v);
    return (v > 255) ? 255 : v;
  endfunction

  // Launch a run; optionally pulse a stray start mid-run.
  task automatic run(input logic [7:0] a, b, s, input bit stray,
                     output int len, output int pbits, output int sbits);
    @(negedge clk);
    op_a = a; op_b = b; op_s = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op_a = ~a; op_b = ~b; op_s = ~s;
    len = 0; pbits = 0; sbits = 0;
    for (int n = 1; n <= RUN_LEN + 40; n++) begin
      if (stray && n == 100) start = 1'b1;
      if (stray && n == 101) start = 1'b0;
      @(negedge clk);
      if (stream_valid) begin
        pbits += int'(prod_bit);
        sbits += int'(sum_bit);
      end
      if (done) begin
        len = n;
        break;
      end
    end
  endtask

  initial begin
    int len, pb, sb, pc, sc, extra;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 stream_valid", int'(stream_valid), 0);
    check("R1 prod_est", int'(prod_est), 0);
    check("R1 sum_est", int'(sum_est), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after release", int'(busy), 0);

    // R2 timing and R10 serial tally on one run
    run(8'd200, 8'd100, 8'd64, 1'b0, len, pb, sb);
    model(8'd200, 8'd100, 8'd64, pc, sc);
    check("R2 run length", len, RUN_LEN);
    check("R2 busy low at done", int'(busy), 0);
    check("R10 prod_bit tally", pb, pc);
    check("R10 sum_bit tally", sb, sc);
    @(negedge clk);
    check("R2 done single cycle", int'(done), 0);
    check("R10 stream_valid drops", int'(stream_valid), 0);
    check("R6 prod_est held", int'(prod_est), sat(pc));

    // R3 R4 R5 R6 sweep over a 16x16 operand grid
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [7:0] a, b, s;
        a = 8'(i * 17); b = 8'(j * 17); s = 8'(((i * 5 + j * 3) % 16) * 17);
        run(a, b, s, 1'b0, len, pb, sb);
        model(a, b, s, pc, sc);
        check("R4 R6 product estimate", int'(prod_est), sat(pc));
        check("R5 R6 sum estimate", int'(sum_est), sat(sc));
      end
    end

    // R7 zero operand
    run(8'd0, 8'd255, 8'd0, 1'b0, len, pb, sb);
    check("R7 zero product estimate", int'(prod_est), 0);
    check("R7 zero product bits", pb, 0);
    model(8'd0, 8'd255, 8'd0, pc, sc);
    check("R3 R5 select zero picks b", int'(sum_est), sat(sc));

    // R8 full-scale operands
    run(8'd255, 8'd255, 8'd255, 1'b0, len, pb, sb);
    check("R8 full scale product >= 254", int'(prod_est >= 8'd254), 1);
    check("R8 sum bits >= 255", int'(sb >= 255), 1);

    // R9 stray start during a run
    run(8'd90, 8'd180, 8'd128, 1'b1, len, pb, sb);
    model(8'd90, 8'd180, 8'd128, pc, sc);
    check("R9 run length unchanged", len, RUN_LEN);
    check("R9 product from first operands", int'(prod_est), sat(pc));
    check("R9 sum from first operands", int'(sum_est), sat(sc));
    extra = 0;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      extra += int'(done) + int'(busy);
    end
    check("R9 no second run", extra, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule